// File: doc/BRIEF.md
# Register-Mapped Serial Port with Echo Mode

This block is an asynchronous serial port seen by a processor through a small synchronous register port. The port has a 12-bit address, an 8-bit write bus, an 8-bit read bus and single-cycle write and read strobes. All of these are sampled on the rising clock edge. Bytes written to the data address are queued in a 32-entry transmit FIFO. The transmit engine sends each queued byte as a frame with one start bit, eight data bits and one stop bit, and no parity.

A receive engine recovers frames from the serial input. It uses an oversampling tick whose rate comes from a divisor split over two configuration registers. When the echo bit is set, every byte received correctly is queued for transmission again, so a remote device sees its own bytes come back on the serial output. Received bytes do not go to the processor. The receive path is visible only through the echo.

Top module: `uart_regport`

## Requirements
- R1: Reset is synchronous and active high. During reset and afterwards, `ser_out` is high and `cpu_rdata` is 0. Both configuration registers and the FIFO are cleared.
- R2: Addresses 0x002 and 0x003 are read/write configuration registers. A read strobe loads `cpu_rdata` at the same clock edge, so the value is valid one cycle after the strobe. `cpu_rdata` keeps its value in cycles with no read strobe.
- R3: A read of address 0x001 returns 0x08 while the transmit FIFO holds 32 bytes. It returns 0x00 otherwise: bit 3 is the full flag and every other bit reads 0.
- R4: A write to address 0x000 queues the byte. A write that arrives while the FIFO is full is dropped. Accepted bytes are transmitted in the order they were written.
- R5: Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts 16 ticks, and a queued byte starts immediately after the previous stop bit.
- R6: The divisor is {reg 0x003, reg 0x002 bits 6:0}, which is 15 bits wide. One tick occurs every divisor+1 clocks, so a bit lasts 16*(divisor+1) clocks.
- R7: After a falling edge, the receiver accepts a start bit only if the input is still low half a bit later. A shorter low pulse produces no byte.
- R8: A frame whose stop bit samples low is discarded. The receiver then waits for the next falling edge.
- R9: With bit 7 of register 0x002 set, every byte received correctly is transmitted on `ser_out`, in arrival order. Echo bytes are sent ahead of bytes waiting in the FIFO.
- R10: With bit 7 of register 0x002 clear, traffic on `ser_in` has no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 12 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_rd | input | 1 | Single-cycle read strobe |
| cpu_rdata | output | 8 | Registered read data |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line, idles high |

## Verification
The bench builds the block with its default parameters: a 32-entry FIFO and 16 ticks per bit. Most traffic runs at divisor 0, which makes a bit 16 clocks long. At that rate the bench can overfill the FIFO within one frame time and can run echo traffic back to back. Divisors of 1 and 128 are also exercised. The second value sets only the high register, so it confirms that the two registers are joined with the high byte in the right place.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam logic [11:0] A_TXDATA = 12'h000;
  localparam logic [11:0] A_STATUS = 12'h001;
  localparam logic [11:0] A_CFG_LO = 12'h002;
  localparam logic [11:0] A_CFG_HI = 12'h003;

  localparam int FULL_BIT = 3;
  localparam int ECHO_BIT = 7;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } ser_state_e;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         have_data,
  input  logic [W-1:0] data,
  output logic         take,
  output logic         txd
);

  localparam int CW = $clog2(OSR);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  ser_state_e    state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg;
  logic          bit_end;

  assign bit_end = (cnt == CW'(OSR-1));
  // a new byte is loaded from idle or straight out of the final stop tick
  assign take = tick && have_data &&
                ((state == S_IDLE) || ((state == S_STOP) && bit_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      txd   <= 1'b1;
    end else if (tick) begin
      if (take) begin
        shreg <= data;
        txd   <= 1'b0;
        cnt   <= '0;
        state <= S_START;
      end else begin
        case (state)
          S_IDLE: txd <= 1'b1;
          S_START: begin
            if (bit_end) begin
              cnt   <= '0;
              bitn  <= '0;
              txd   <= shreg[0];
              shreg <= shreg >> 1;
              state <= S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              if (bitn == BW'(W-1)) begin
                txd   <= 1'b1;
                state <= S_STOP;
              end else begin
                txd   <= shreg[0];
                shreg <= shreg >> 1;
                bitn  <= bitn + 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (bit_end) begin
              cnt   <= '0;
              state <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         rxd,
  output logic         valid,
  output logic [W-1:0] data
);

  localparam int CW = $clog2(OSR);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  ser_state_e    state;
  logic [1:0]    sync;
  logic          prev;
  logic          cur;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg;

  assign cur = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      prev <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (prev && !cur) begin
            cnt   <= '0;
            state <= S_START;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == CW'(OSR/2 - 1)) begin
              cnt   <= '0;
              bitn  <= '0;
              state <= cur ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (tick) begin
            if (cnt == CW'(OSR-1)) begin
              cnt   <= '0;
              shreg <= {cur, shreg[W-1:1]};
              if (bitn == BW'(W-1)) state <= S_STOP;
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (tick) begin
            if (cnt == CW'(OSR-1)) begin
              cnt   <= '0;
              state <= S_IDLE;
              if (cur) begin
                valid <= 1'b1;
                data  <= shreg;
              end
            end else cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int OSR        = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata,
  input  logic        ser_in,
  output logic        ser_out
);

  localparam int W     = 8;
  localparam int DIV_W = 2*W - 1;
  localparam int LW    = $clog2(FIFO_DEPTH+1);

  logic [W-1:0]     cfg_lo, cfg_hi;
  logic [DIV_W-1:0] baud_div;
  logic             baud_tick;
  logic             echo_en;

  logic             fifo_empty, fifo_full, fifo_pop;
  logic [W-1:0]     fifo_dout;
  logic [LW-1:0]    fifo_level;

  logic             rx_valid;
  logic [W-1:0]     rx_data;
  logic             echo_valid;
  logic [W-1:0]     echo_data;

  logic             tx_have, tx_take;
  logic [W-1:0]     tx_data;

  assign baud_div = {cfg_hi, cfg_lo[W-2:0]};
  assign echo_en  = cfg_lo[ECHO_BIT];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_lo <= '0;
      cfg_hi <= '0;
    end else if (cpu_wr) begin
      if (cpu_addr == A_CFG_LO) cfg_lo <= cpu_wdata;
      if (cpu_addr == A_CFG_HI) cfg_hi <= cpu_wdata;
    end
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_rd) begin
      case (cpu_addr)
        A_STATUS: begin
          cpu_rdata           <= '0;
          cpu_rdata[FULL_BIT] <= fifo_full;
        end
        A_CFG_LO: cpu_rdata <= cfg_lo;
        A_CFG_HI: cpu_rdata <= cfg_hi;
        default:  cpu_rdata <= '0;
      endcase
    end
  end

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (baud_div),
    .tick (baud_tick)
  );

  uart_tx_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (cpu_wr && (cpu_addr == A_TXDATA)),
    .din   (cpu_wdata),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  uart_rx_core #(.W(W), .OSR(OSR)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .rxd   (ser_in),
    .valid (rx_valid),
    .data  (rx_data)
  );

  // single-byte echo holding register, served ahead of the FIFO
  always_ff @(posedge clk) begin
    if (rst) begin
      echo_valid <= 1'b0;
      echo_data  <= '0;
    end else if (rx_valid && echo_en) begin
      echo_valid <= 1'b1;
      echo_data  <= rx_data;
    end else if (tx_take && echo_valid) begin
      echo_valid <= 1'b0;
    end
  end

  assign tx_have  = echo_valid || !fifo_empty;
  assign tx_data  = echo_valid ? echo_data : fifo_dout;
  assign fifo_pop = tx_take && !echo_valid;

  uart_tx_core #(.W(W), .OSR(OSR)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .have_data (tx_have),
    .data      (tx_data),
    .take      (tx_take),
    .txd       (ser_out)
  );

endmodule

// File: rtl/uart_regport_chk.sv
module uart_regport_chk #(
  parameter int FIFO_DEPTH = 32,
  parameter int LW         = 6,
  parameter int DIV_W      = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [11:0]      cpu_addr,
  input logic [7:0]       cpu_wdata,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic [7:0]       cpu_rdata,
  input logic             ser_out,
  input logic             baud_tick,
  input logic [LW-1:0]    fifo_level,
  input logic [DIV_W-1:0] baud_div
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ser_out && cpu_rdata == 8'h00));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));

  p_cfg_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 12'h002) ##1 (cpu_rd && !cpu_wr && cpu_addr == 12'h002)
    |=> cpu_rdata == $past(cpu_wdata, 2));

  p_status_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 12'h001) |=> (cpu_rdata & 8'hF7) == 8'h00);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(FIFO_DEPTH));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 12'h000 && fifo_level == LW'(FIFO_DEPTH))
    |=> (fifo_level == LW'(FIFO_DEPTH) || fifo_level == LW'(FIFO_DEPTH-1)));

  p_tx_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_out) |-> $past(baud_tick));

  p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && baud_div != '0) |=> !baud_tick);

endmodule

bind uart_regport uart_regport_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .LW         (LW),
  .DIV_W      (DIV_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .cpu_rdata  (cpu_rdata),
  .ser_out    (ser_out),
  .baud_tick  (baud_tick),
  .fifo_level (fifo_level),
  .baud_div   (baud_div)
);

// File: tb/uart_regport_tb.sv
module uart_regport_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic        cpu_rd;
  logic [7:0]  cpu_rdata;
  logic        ser_in;
  logic        ser_out;

  int n_checks = 0;
  int n_fail   = 0;
  int bitclk   = 16;
  int got_cnt  = 0;
  int low_cnt  = 0;
  bit done     = 1'b0;
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regport u_dut (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .ser_in    (ser_in),
    .ser_out   (ser_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_val);
    @(negedge clk);
    ser_in = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      repeat (bitclk) @(negedge clk);
    end
    ser_in = stop_val;
    repeat (bitclk) @(negedge clk);
    ser_in = 1'b1;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2*bitclk) @(negedge clk);
  endtask

  // low-time counter on the serial output
  always @(negedge clk) if (!rst && ser_out === 1'b0) low_cnt++;

  // monitor: decodes frames on ser_out and compares against the scoreboard
  initial begin
    logic prev_o;
    logic [7:0] b;
    prev_o = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && prev_o && !ser_out) begin
        repeat (bitclk/2) @(negedge clk);
        if (ser_out) chk(1'b0, "R5 start bit", 1, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitclk) @(negedge clk);
          b[i] = ser_out;
        end
        repeat (bitclk) @(negedge clk);
        chk(ser_out === 1'b1, "R5 stop bit", int'(ser_out), 1);
        got_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R4/R9 unexpected byte", int'(b), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(b == e, "R5 byte order", int'(b), int'(e));
        end
      end
      prev_o = ser_out;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int base, n, lows;
    rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; ser_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(ser_out === 1'b1, "R1 idle in reset", int'(ser_out), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_rdata == 8'h00, "R1 rdata after reset", cpu_rdata, 0);
    cpu_read(12'h002, rd); chk(rd == 8'h00, "R1 cfg lo cleared", rd, 0);
    cpu_read(12'h003, rd); chk(rd == 8'h00, "R1 cfg hi cleared", rd, 0);
    cpu_read(12'h001, rd); chk(rd == 8'h00, "R3 status empty", rd, 0);

    // R2 readback
    cpu_write(12'h002, 8'h55);
    cpu_write(12'h003, 8'hAA);
    cpu_read(12'h002, rd); chk(rd == 8'h55, "R2 cfg lo readback", rd, 8'h55);
    cpu_read(12'h003, rd); chk(rd == 8'hAA, "R2 cfg hi readback", rd, 8'hAA);
    repeat (3) @(negedge clk);
    chk(cpu_rdata == 8'hAA, "R2 rdata held", cpu_rdata, 8'hAA);
    cpu_write(12'h003, 8'h00);
    cpu_write(12'h002, 8'h00);
    repeat (4) @(negedge clk);

    // R10 no echo when disabled
    lows = low_cnt;
    send_frame(8'h00, 1'b1);
    repeat (100) @(negedge clk);
    chk(low_cnt == lows, "R10 no echo", low_cnt - lows, 0);

    // R5 frames at divisor 0
    foreach (exp_q[i]) ;
    exp_q.push_back(8'hA5); cpu_write(12'h000, 8'hA5);
    exp_q.push_back(8'h3C); cpu_write(12'h000, 8'h3C);
    exp_q.push_back(8'h01); cpu_write(12'h000, 8'h01);
    exp_q.push_back(8'h80); cpu_write(12'h000, 8'h80);
    wait_drain();

    // R6 divisor 1 -> 32 clocks per bit
    cpu_write(12'h002, 8'h01);
    bitclk = 32;
    exp_q.push_back(8'hFF); cpu_write(12'h000, 8'hFF);
    while (ser_out) @(negedge clk);
    n = 0;
    while (!ser_out) begin n++; @(negedge clk); end
    chk(n == 32, "R6 bit width div 1", n, 32);
    wait_drain();

    // R6 high register weight: divisor 128 -> 2064 clocks per bit
    cpu_write(12'h002, 8'h00);
    cpu_write(12'h003, 8'h01);
    bitclk = 2064;
    exp_q.push_back(8'h0F); cpu_write(12'h000, 8'h0F);
    while (ser_out) @(negedge clk);
    n = 0;
    while (!ser_out) begin n++; @(negedge clk); end
    chk(n == 2064, "R6 bit width div 128", n, 2064);
    wait_drain();
    cpu_write(12'h003, 8'h00);
    bitclk = 16;
    repeat (300) @(negedge clk);

    // R3/R4: first byte leaves the FIFO at once, 32 more fill it, the 34th is dropped
    base = got_cnt;
    for (int k = 1; k <= 34; k++) begin
      if (k <= 33) exp_q.push_back(8'(k));
      cpu_write(12'h000, 8'(k));
    end
    cpu_read(12'h001, rd); chk(rd == 8'h08, "R3 full flag set", rd, 8'h08);
    repeat (250) @(negedge clk);
    cpu_read(12'h001, rd); chk(rd == 8'h00, "R3 full flag clears", rd, 0);
    wait_drain();
    chk(got_cnt - base == 33, "R4 dropped write", got_cnt - base, 33);

    // R9 echo, R8 bad stop, R7 glitch
    cpu_write(12'h002, 8'h80);
    repeat (4) @(negedge clk);
    base = got_cnt;
    exp_q.push_back(8'h5A); send_frame(8'h5A, 1'b1);
    exp_q.push_back(8'hC3); send_frame(8'hC3, 1'b1);
    send_frame(8'h99, 1'b0);
    repeat (3*bitclk) @(negedge clk);
    ser_in = 1'b0;
    repeat (4) @(negedge clk);
    ser_in = 1'b1;
    repeat (3*bitclk) @(negedge clk);
    exp_q.push_back(8'h77); send_frame(8'h77, 1'b1);
    wait_drain();
    repeat (400) @(negedge clk);
    chk(got_cnt - base == 3, "R9 echo count (R7 R8 discards)", got_cnt - base, 3);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end

endmodule